// File: doc/BRIEF.md
# Two-Lane Vector Compare and Condition Evaluator

This block executes the vector compare instruction of a shader core and supplies the condition test that conditional branches use. On a compare it looks at the first two lanes (x and y) of two four-lane single-precision source vectors. Each lane applies its own relational operator, and the two one-bit outcomes are stored in a two-bit flag register. Lanes z and w are ignored.

A separate combinational path reads the stored flags together with two reference bits and a combine mode from the current instruction word. It drives a single condition-true output, which the sequencer uses to take or skip a conditional block.

The sequencer presents an instruction word, the two already-fetched and swizzled source vectors, and a write enable. An index field that this block does not support is flagged on an error output.

Top module: `shader_cmp_unit`

## Requirements
- R1: An instruction is a compare when its opcode field, bits 31:26, is 0x2E or 0x2F. Bit 26 is shared with the y operator field. Any other opcode never writes the flags, even when the write enable is high.
- R2: The x operator is read from bits 23:21 and the y operator from bits 26:24. The x lane is bits 31:0 of each source and the y lane is bits 63:32. The x result goes to flag bit 0 and the y result to flag bit 1. Source bits 127:64 have no effect.
- R3: Operator codes have these meanings: 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal. Each compares the first source against the second.
- R4: Operator codes 6 and 7 set the flag to 1 regardless of the operands, NaN included.
- R5: If either operand is a NaN, every operator from 0 to 5 gives 0, except not-equal, which gives 1.
- R6: Ordering follows IEEE-754 single precision, including negative values, and +0 equals -0.
- R7: The flags reset to 00. They load at the rising clock edge when the write enable is high and the instruction is a valid compare. Otherwise they hold.
- R8: For a compare with a nonzero index field (bits 20:19), the error output is high in the same cycle and the flags are not written.
- R9: The condition test reads its mode from bits 23:22, reference x from bit 24 and reference y from bit 25. It evaluates against the current flags combinationally.
- R10: Mode 0 is true when flag 0 equals reference x or flag 1 equals reference y. Mode 1 is true only when both flags equal their references.
- R11: Mode 2 is true when flag 0 equals reference x, ignoring y. Mode 3 is true when flag 1 equals reference y, ignoring x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcA | input | 128 | First source vector, lane x in bits 31:0 |
| srcB | input | 128 | Second source vector, lane x in bits 31:0 |
| instr | input | 32 | Current instruction word |
| wrEn | input | 1 | Commit strobe for a compare |
| cmpFlags | output | 2 | Stored compare flags, bit 0 x, bit 1 y |
| condTrue | output | 1 | Condition result against the stored flags |
| idxErr | output | 1 | Unsupported index field on a compare |

## Verification
The compare flags are due one rising edge after a committed compare. The scoreboard queues each expected flag pair at the falling edge where the stimulus is driven. The monitor pops it just after the following rising edge. The error output and the condition result have no register in their path, so they are checked in the same half cycle, about a nanosecond after the inputs settle at the falling edge. Hold cases queue the previously expected flags, so an unwanted write shows up at the same sampling point.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int FP_W      = 32;
  localparam int VEC_LANES = 4;
  localparam int CMP_LANES = 2;
  localparam int VEC_W     = FP_W * VEC_LANES;

  typedef enum logic [2:0] {
    OP_EQ  = 3'd0,
    OP_NE  = 3'd1,
    OP_LT  = 3'd2,
    OP_LE  = 3'd3,
    OP_GT  = 3'd4,
    OP_GE  = 3'd5,
    OP_T6  = 3'd6,
    OP_T7  = 3'd7
  } cmpOp_t;

  typedef enum logic [1:0] {
    CM_ANY   = 2'd0,
    CM_BOTH  = 2'd1,
    CM_XONLY = 2'd2,
    CM_YONLY = 2'd3
  } condMode_t;

  typedef struct packed {
    logic wrFlags;
    logic idxErr;
  } ctrlStrb_t;
endpackage

// File: rtl/cmp_lane.sv
module cmp_lane #(
  parameter int FP_W  = 32,
  parameter int EXP_W = 8
) (
  input  logic [FP_W-1:0] opA,
  input  logic [FP_W-1:0] opB,
  input  cmp_pkg::cmpOp_t op,
  output logic            res
);
  import cmp_pkg::*;
  localparam int MAN_W = FP_W - 1 - EXP_W;

  logic signA, signB, nanA, nanB, anyNan, bothZero;
  logic [FP_W-2:0] magA, magB;
  logic isEq, isLt, isGt, ordLt;

  always_comb begin
    signA    = opA[FP_W-1];
    signB    = opB[FP_W-1];
    magA     = opA[FP_W-2:0];
    magB     = opB[FP_W-2:0];
    nanA     = (&opA[FP_W-2:MAN_W]) && (|opA[MAN_W-1:0]);
    nanB     = (&opB[FP_W-2:MAN_W]) && (|opB[MAN_W-1:0]);
    anyNan   = nanA || nanB;
    bothZero = (magA == '0) && (magB == '0);
    if (bothZero)           ordLt = 1'b0;
    else if (signA != signB) ordLt = signA;
    else if (!signA)         ordLt = magA < magB;
    else                     ordLt = magA > magB;
    isEq = !anyNan && ((opA == opB) || bothZero);
    isLt = !anyNan && ordLt;
    isGt = !anyNan && !isLt && !isEq;
    unique case (op)
      OP_EQ:   res = isEq;
      OP_NE:   res = !isEq;
      OP_LT:   res = isLt;
      OP_LE:   res = isLt || isEq;
      OP_GT:   res = isGt;
      OP_GE:   res = isGt || isEq;
      default: res = 1'b1;
    endcase
  end

  always_comb begin
    // R5
    if (anyNan && (op inside {OP_EQ, OP_LT, OP_LE, OP_GT, OP_GE}))
      nan_false_chk: assert (!res);
  end
endmodule

// File: rtl/cmp_ctrl.sv
module cmp_ctrl (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        instr,
  input  logic               wrEn,
  output cmp_pkg::ctrlStrb_t strb,
  output cmp_pkg::cmpOp_t    opX,
  output cmp_pkg::cmpOp_t    opY,
  output cmp_pkg::condMode_t mode,
  output logic               refX,
  output logic               refY
);
  import cmp_pkg::*;
  localparam logic [4:0] CMP_OPC_HI = 5'b10111;

  logic isCmp;
  logic unusedLowBits;

  always_comb begin
    isCmp        = (instr[31:27] == CMP_OPC_HI);
    strb.idxErr  = isCmp && (instr[20:19] != 2'b00);
    strb.wrFlags = wrEn && isCmp && !strb.idxErr;
    opX          = cmpOp_t'(instr[23:21]);
    opY          = cmpOp_t'(instr[26:24]);
    mode         = condMode_t'(instr[23:22]);
    refX         = instr[24];
    refY         = instr[25];
    unusedLowBits = ^instr[18:0];
  end

  // R8
  idx_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.idxErr |-> !strb.wrFlags);

  // R1
  opc_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instr[31:26] != 6'h2E && instr[31:26] != 6'h2F) |-> !strb.wrFlags);
endmodule

// File: rtl/cmp_datapath.sv
module cmp_datapath #(
  parameter int FP_W      = 32,
  parameter int VEC_LANES = 4,
  parameter int CMP_LANES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [FP_W*VEC_LANES-1:0]   srcA,
  input  logic [FP_W*VEC_LANES-1:0]   srcB,
  input  cmp_pkg::ctrlStrb_t          strb,
  input  cmp_pkg::cmpOp_t             opX,
  input  cmp_pkg::cmpOp_t             opY,
  input  cmp_pkg::condMode_t          mode,
  input  logic                        refX,
  input  logic                        refY,
  output logic [CMP_LANES-1:0]        cmpFlags,
  output logic                        condTrue
);
  import cmp_pkg::*;
  localparam int USED_W = FP_W * CMP_LANES;

  logic [CMP_LANES-1:0] laneRes;
  cmpOp_t               laneOp [CMP_LANES];
  logic                 unusedUpper;
  logic                 matchX, matchY;

  assign laneOp[0] = opX;
  assign laneOp[1] = opY;
  assign unusedUpper = ^{srcA[FP_W*VEC_LANES-1:USED_W], srcB[FP_W*VEC_LANES-1:USED_W]};

  for (genvar i = 0; i < CMP_LANES; i++) begin : g_lane
    cmp_lane #(.FP_W(FP_W), .EXP_W(8)) u_lane (
      .opA (srcA[i*FP_W +: FP_W]),
      .opB (srcB[i*FP_W +: FP_W]),
      .op  (laneOp[i]),
      .res (laneRes[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cmpFlags <= '0;
    else if (strb.wrFlags) cmpFlags <= laneRes;
  end

  always_comb begin
    matchX = (cmpFlags[0] == refX);
    matchY = (cmpFlags[1] == refY);
    unique case (mode)
      CM_ANY:   condTrue = matchX || matchY;
      CM_BOTH:  condTrue = matchX && matchY;
      CM_XONLY: condTrue = matchX;
      default:  condTrue = matchY;
    endcase
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrFlags |=> $stable(cmpFlags));

  // R4
  force_true_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrFlags && opX[2:1] == 2'b11) |=> cmpFlags[0]);

  // R10
  both_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (condTrue && mode == CM_BOTH) |-> (cmpFlags[0] == refX && cmpFlags[1] == refY));

  // R11
  xonly_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == CM_XONLY) |-> (condTrue == (cmpFlags[0] == refX)));
endmodule

// File: rtl/shader_cmp_unit.sv
module shader_cmp_unit (
  input  logic         clk,
  input  logic         rstN,
  input  logic [127:0] srcA,
  input  logic [127:0] srcB,
  input  logic [31:0]  instr,
  input  logic         wrEn,
  output logic [1:0]   cmpFlags,
  output logic         condTrue,
  output logic         idxErr
);
  import cmp_pkg::*;

  ctrlStrb_t strb;
  cmpOp_t    opX, opY;
  condMode_t mode;
  logic      refX, refY;

  cmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instr(instr), .wrEn(wrEn), .strb(strb),
    .opX(opX), .opY(opY), .mode(mode), .refX(refX), .refY(refY)
  );

  cmp_datapath #(.FP_W(FP_W), .VEC_LANES(VEC_LANES), .CMP_LANES(CMP_LANES)) u_dp (
    .clk(clk), .rstN(rstN), .srcA(srcA), .srcB(srcB), .strb(strb),
    .opX(opX), .opY(opY), .mode(mode), .refX(refX), .refY(refY),
    .cmpFlags(cmpFlags), .condTrue(condTrue)
  );

  assign idxErr = strb.idxErr;
endmodule

// File: tb/shader_cmp_unit_bench.sv
module shader_cmp_unit_bench;
  localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000;
  localparam logic [31:0] N1 = 32'hBF800000, N2 = 32'hC0000000;
  localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
  localparam logic [31:0] QN = 32'h7FC00000;

  typedef struct {
    logic [1:0] flags;
    string      req;
  } item_t;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [127:0] srcA = '0, srcB = '0;
  logic [31:0] instr = '0;
  logic [1:0] cmpFlags;
  logic condTrue, idxErr;
  int nChecks = 0, nFails = 0;
  logic [1:0] modelFlags = 2'b00;
  item_t sbq[$];
  bit finished = 0;

  always #2 clk = ~clk;

  shader_cmp_unit u_shader_cmp_unit (
    .clk(clk), .rstN(rstN), .srcA(srcA), .srcB(srcB), .instr(instr),
    .wrEn(wrEn), .cmpFlags(cmpFlags), .condTrue(condTrue), .idxErr(idxErr)
  );

  function automatic logic [31:0] mkCmp(input logic [2:0] opX, input logic [2:0] opY,
                                        input logic [1:0] idx);
    return {5'b10111, opY, opX, idx, 19'd0};
  endfunction

  function automatic logic [31:0] mkCond(input logic [1:0] mode, input logic rx, input logic ry);
    return {6'h28, ry, rx, mode, 22'd0};
  endfunction

  task automatic check1(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] ax, input logic [31:0] ay, input logic [31:0] bx,
                       input logic [31:0] by, input logic [31:0] ins, input logic we,
                       input logic [1:0] expWr, input logic expErr, input string req);
    item_t it;
    @(negedge clk);
    srcA = {{2{32'h7FC00001}}, ay, ax};
    srcB = {{2{32'hFF800000}}, by, bx};
    instr = ins;
    wrEn = we;
    #1;
    check1({req, " err"}, idxErr, expErr);
    if (we && !expErr && ins[31:27] == 5'b10111) modelFlags = expWr;
    it.flags = modelFlags;
    it.req = req;
    sbq.push_back(it);
  endtask

  task automatic cond(input logic [1:0] mode, input logic rx, input logic ry,
                      input logic exp, input string req);
    @(negedge clk);
    wrEn = 1'b0;
    instr = mkCond(mode, rx, ry);
    #1;
    check1(req, condTrue, exp);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        nChecks++;
        if (cmpFlags !== it.flags) begin
          nFails++;
          $display("FAIL %s: actual %b expected %b", it.req, cmpFlags, it.flags);
        end
      end
    end
  end

  initial begin : watchdog
    #(4 * 200000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R7 reset state
    check1("R7 reset flag0", cmpFlags[0], 1'b0);
    check1("R7 reset flag1", cmpFlags[1], 1'b0);
    // R3 less-than per lane, opcode 0x2E
    drive(P1, P2, P2, P1, mkCmp(3'd2, 3'd2, 2'd0), 1'b1, 2'b01, 1'b0, "R3 lt");
    // R3 eq/ne
    drive(P1, P1, P1, P1, mkCmp(3'd0, 3'd1, 2'd0), 1'b1, 2'b01, 1'b0, "R3 eq ne");
    // R1 opcode 0x2F (opY=4), R6 negatives: -1 > -2
    drive(P2, N1, P2, N2, mkCmp(3'd3, 3'd4, 2'd0), 1'b1, 2'b11, 1'b0, "R1 R6 le gt");
    // R6 -2 >= -1 false, 2 > -1 true
    drive(N2, P2, N1, N1, mkCmp(3'd5, 3'd4, 2'd0), 1'b1, 2'b10, 1'b0, "R6 ge gt");
    // R6 signed zeros
    drive(PZ, NZ, NZ, PZ, mkCmp(3'd0, 3'd2, 2'd0), 1'b1, 2'b01, 1'b0, "R6 zero");
    // R5 NaN eq false, ne true
    drive(QN, QN, P1, QN, mkCmp(3'd0, 3'd1, 2'd0), 1'b1, 2'b10, 1'b0, "R5 nan eq ne");
    // R5 NaN ge / lt false
    drive(QN, P1, P1, QN, mkCmp(3'd5, 3'd2, 2'd0), 1'b1, 2'b00, 1'b0, "R5 nan ge lt");
    // R4 codes 6 and 7
    drive(QN, QN, P1, QN, mkCmp(3'd6, 3'd7, 2'd0), 1'b1, 2'b11, 1'b0, "R4 forced");
    // R7 hold with write enable low
    drive(P1, P1, P2, P2, mkCmp(3'd0, 3'd0, 2'd0), 1'b0, 2'b00, 1'b0, "R7 hold");
    // R1 non-compare opcode ignored
    drive(P1, P1, P2, P2, 32'h4C000000, 1'b1, 2'b00, 1'b0, "R1 other opcode");
    // R8 index error blocks write
    drive(P1, P1, P2, P2, mkCmp(3'd0, 3'd0, 2'd1), 1'b1, 2'b00, 1'b1, "R8 idx");
    drive(P1, P1, P2, P2, mkCmp(3'd0, 3'd0, 2'd2), 1'b0, 2'b00, 1'b1, "R8 idx2");
    // R2 lane mapping, upper lanes NaN/garbage
    drive(P1, P1, P1, P2, mkCmp(3'd0, 3'd0, 2'd0), 1'b1, 2'b01, 1'b0, "R2 lanes");
    @(negedge clk);
    wrEn = 1'b0;
    // flags now 01: flag0=1 flag1=0 (R9 fields)
    cond(2'd0, 1'b1, 1'b1, 1'b1, "R10 any hit");
    cond(2'd0, 1'b0, 1'b1, 1'b0, "R10 any miss");
    cond(2'd1, 1'b1, 1'b0, 1'b1, "R10 both hit");
    cond(2'd1, 1'b1, 1'b1, 1'b0, "R10 both miss");
    cond(2'd2, 1'b1, 1'b1, 1'b1, "R11 x hit");
    cond(2'd2, 1'b0, 1'b0, 1'b0, "R11 x miss");
    cond(2'd3, 1'b0, 1'b0, 1'b1, "R11 y hit");
    cond(2'd3, 1'b1, 1'b1, 1'b0, "R9 y miss");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule